// File: doc/BRIEF.md
# Unlock-Sequence Flash Bank Sequencer

This block drives a byte-wide flash through a whole-bank erase or a whole-bank program. The flash accepts a command only after a two-write unlock handshake, and it shows that an internal operation is still running by flipping a bit on every read. The sequencer issues the unlock and command writes with a minimum spacing between them. After each command it reads the bank base twice in a row, and it treats two equal reads as completion. A limit on the number of read pairs turns a stuck operation into a timeout. Every operation ends with an exit-to-read-mode write, followed by a read-back pass over the whole bank.

A controller pulses `start` with `op_prog` (0 = erase, 1 = program) and `bank_sel`. While programming, the block fetches source bytes through `src_addr`/`src_data`. That port is a combinational lookup: `src_data` must reflect `src_addr` in the same cycle. The flash port uses one-cycle write strobes. Reads are synchronous: `fl_rdata` is valid in the cycle after `fl_re`. `done` pulses for one cycle at the end of an operation. `timeout` and `verify_fail` are valid from that cycle and hold until the next accepted start.

The state machine has these states. IDLE goes to CMD_WR on start. CMD_WR (one command write) goes to CMD_GAP. CMD_GAP waits out the spacing, then goes back to CMD_WR for the next step, or to POLL_RD1 after the last step. The poll loop runs POLL_RD1 → POLL_CAP1 → POLL_RD2 → POLL_CAP2. From POLL_CAP2, equal reads go to CMD_WR for the next byte when programming, or to EXIT_WR. Unequal reads go back to POLL_RD1, or to EXIT_WR at the pair limit. EXIT_WR goes to EXIT_GAP and then to VFY_RD. VFY_RD and VFY_CAP alternate once per byte. After the last byte the machine goes to FIN, which raises done, and then back to IDLE.

Top module: `unlock_flash_seq`

## Requirements
- R1: After reset, busy, done, fl_we, fl_re, timeout and verify_fail are all 0.
- R2: Every command is preceded by an unlock pair: 0xAA written to bank base + UNLOCK_A_OFF, then 0x55 written to bank base + UNLOCK_B_OFF.
- R3: Erase writes, in order: unlock, 0x80 to base + UNLOCK_A_OFF, unlock, then 0x30 to the bank base.
- R4: Program visits the bytes at ascending offsets 0 to BANK_BYTES-1. For each byte it writes unlock, then 0xA0 to base + UNLOCK_A_OFF, then src_data (with src_addr equal to the offset) to base + offset.
- R5: After every flash write, the flash bus stays idle for at least GAP_CYCLES cycles before the next read or write.
- R6: After each command, the block reads the bank base in pairs. It moves on once a pair returns equal values.
- R7: After POLL_LIMIT unequal pairs the operation times out: timeout is set and programming writes no further bytes.
- R8: Every operation, including one that timed out, writes 0xF0 to the bank base as its final write, followed by the spacing gap.
- R9: After the exit write, all BANK_BYTES bytes of the bank are read once. verify_fail is set if any byte differs from 0xFF (erase) or from the source byte (program).
- R10: done is a one-cycle pulse and busy is low in the following cycle. timeout and verify_fail hold their values from done until the next accepted start, which clears them.
- R11: A start pulse while busy is ignored and does not change the ongoing write sequence.
- R12: Every flash access lies in the bank latched at start (address = bank × BANK_BYTES + offset), and fl_we and fl_re are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation when idle |
| op_prog | input | 1 | 0 = erase bank, 1 = program bank |
| bank_sel | input | BANK_W | Bank index |
| src_addr | output | log2(BANK_BYTES) | Source buffer byte offset |
| src_data | input | 8 | Source buffer byte at src_addr |
| fl_addr | output | BANK_W+log2(BANK_BYTES) | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid the cycle after fl_re |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last operation hit the poll limit |
| verify_fail | output | 1 | Last read-back found a mismatch |

## Verification
The bound checker watches every cycle for four things: the spacing after each write, the exclusivity of read and write strobes, that addresses stay inside the latched bank, and that done pulses for one cycle with the flags frozen while idle. Only the bench scenarios can show the order and content of the command stream. The bench compares each write against a queue built from the requirements. The scenarios also show:
- the poll-pair count for a given busy duration;
- abort after the first byte on timeout;
- that a start pulse while busy is ignored;
- that an injected stuck byte or stuck bit raises verify_fail.

// File: rtl/ufs_pkg.sv
package ufs_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] ERASE_ARM  = 8'h80;
    localparam logic [7:0] ERASE_GO   = 8'h30;
    localparam logic [7:0] PROG_ARM   = 8'hA0;
    localparam logic [7:0] EXIT_CMD   = 8'hF0;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        AS_KEY_A,
        AS_KEY_B,
        AS_BASE,
        AS_BYTE
    } addr_sel_e;

    typedef struct packed {
        addr_sel_e  asel;
        logic       use_src;
        logic [7:0] data;
        logic       last;
    } cmd_step_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_WR,
        ST_CMD_GAP,
        ST_POLL_RD1,
        ST_POLL_CAP1,
        ST_POLL_RD2,
        ST_POLL_CAP2,
        ST_EXIT_WR,
        ST_EXIT_GAP,
        ST_VFY_RD,
        ST_VFY_CAP,
        ST_FIN
    } seq_state_e;

    function automatic cmd_step_t step_lookup(input logic prog, input logic [2:0] idx);
        cmd_step_t s;
        s = '{asel: AS_BASE, use_src: 1'b0, data: 8'h00, last: 1'b0};
        if (prog) begin
            unique case (idx)
                3'd0: s = '{asel: AS_KEY_A, use_src: 1'b0, data: KEY_FIRST,  last: 1'b0};
                3'd1: s = '{asel: AS_KEY_B, use_src: 1'b0, data: KEY_SECOND, last: 1'b0};
                3'd2: s = '{asel: AS_KEY_A, use_src: 1'b0, data: PROG_ARM,   last: 1'b0};
                3'd3: s = '{asel: AS_BYTE,  use_src: 1'b1, data: 8'h00,      last: 1'b1};
                default: s = '{asel: AS_BASE, use_src: 1'b0, data: 8'h00, last: 1'b1};
            endcase
        end else begin
            unique case (idx)
                3'd0: s = '{asel: AS_KEY_A, use_src: 1'b0, data: KEY_FIRST,  last: 1'b0};
                3'd1: s = '{asel: AS_KEY_B, use_src: 1'b0, data: KEY_SECOND, last: 1'b0};
                3'd2: s = '{asel: AS_KEY_A, use_src: 1'b0, data: ERASE_ARM,  last: 1'b0};
                3'd3: s = '{asel: AS_KEY_A, use_src: 1'b0, data: KEY_FIRST,  last: 1'b0};
                3'd4: s = '{asel: AS_KEY_B, use_src: 1'b0, data: KEY_SECOND, last: 1'b0};
                3'd5: s = '{asel: AS_BASE,  use_src: 1'b0, data: ERASE_GO,   last: 1'b1};
                default: s = '{asel: AS_BASE, use_src: 1'b0, data: 8'h00, last: 1'b1};
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/ufs_cmd_table.sv
module ufs_cmd_table
    import ufs_pkg::*;
(
    input  logic       prog,
    input  logic [2:0] step,
    output cmd_step_t  entry
);
    always_comb entry = step_lookup(prog, step);
endmodule

// File: rtl/ufs_gap_timer.sv
module ufs_gap_timer #(
    parameter int GAP_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(GAP_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ufs_pair_counter.sv
module ufs_pair_counter #(
    parameter int POLL_LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] LAST_PAIR = CW'(POLL_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + CW'(1);
    end

    assign at_limit = (cnt_q == LAST_PAIR);
endmodule

// File: rtl/unlock_flash_seq.sv
module unlock_flash_seq
    import ufs_pkg::*;
#(
    parameter int BANK_BYTES   = 8192,
    parameter int BANK_W       = 1,
    parameter int UNLOCK_A_OFF = 'h555,
    parameter int UNLOCK_B_OFF = 'h2AA,
    parameter int GAP_CYCLES   = 125,
    parameter int POLL_LIMIT   = 1000000,
    localparam int OFF_W       = $clog2(BANK_BYTES),
    localparam int FA_W        = BANK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_prog,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [OFF_W-1:0]  src_addr,
    input  logic [7:0]        src_data,
    output logic [FA_W-1:0]   fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [7:0]        fl_rdata,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              verify_fail
);
    localparam logic [OFF_W-1:0] OFS_A    = OFF_W'(UNLOCK_A_OFF);
    localparam logic [OFF_W-1:0] OFS_B    = OFF_W'(UNLOCK_B_OFF);
    localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(BANK_BYTES - 1);

    seq_state_e        state_q, state_d;
    logic [2:0]        step_q;
    logic [OFF_W-1:0]  idx_q;
    logic              prog_q;
    logic [BANK_W-1:0] bank_q;
    logic [7:0]        first_rd_q;
    logic              tmo_q, vfail_q;

    cmd_step_t entry;
    logic      gap_load, gap_done;
    logic      pair_clr, pair_inc, pair_at_limit;
    logic      pair_equal, last_byte;
    logic [7:0] vfy_expect;

    ufs_cmd_table table_i (
        .prog  (prog_q),
        .step  (step_q),
        .entry (entry)
    );

    ufs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) gap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_done)
    );

    ufs_pair_counter #(.POLL_LIMIT(POLL_LIMIT)) pair_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pair_clr),
        .inc      (pair_inc),
        .at_limit (pair_at_limit)
    );

    assign pair_equal = (fl_rdata == first_rd_q);
    assign last_byte  = (idx_q == LAST_IDX);
    assign vfy_expect = prog_q ? src_data : BLANK_BYTE;
    assign gap_load   = (state_q == ST_CMD_WR) || (state_q == ST_EXIT_WR);
    assign pair_clr   = (state_q == ST_CMD_WR);
    assign pair_inc   = (state_q == ST_POLL_CAP2) && !pair_equal;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_CMD_WR;
            ST_CMD_WR:    state_d = ST_CMD_GAP;
            ST_CMD_GAP:   if (gap_done) state_d = entry.last ? ST_POLL_RD1 : ST_CMD_WR;
            ST_POLL_RD1:  state_d = ST_POLL_CAP1;
            ST_POLL_CAP1: state_d = ST_POLL_RD2;
            ST_POLL_RD2:  state_d = ST_POLL_CAP2;
            ST_POLL_CAP2: begin
                if (pair_equal)
                    state_d = (prog_q && !last_byte) ? ST_CMD_WR : ST_EXIT_WR;
                else if (pair_at_limit)
                    state_d = ST_EXIT_WR;
                else
                    state_d = ST_POLL_RD1;
            end
            ST_EXIT_WR:   state_d = ST_EXIT_GAP;
            ST_EXIT_GAP:  if (gap_done) state_d = ST_VFY_RD;
            ST_VFY_RD:    state_d = ST_VFY_CAP;
            ST_VFY_CAP:   state_d = last_byte ? ST_FIN : ST_VFY_RD;
            ST_FIN:       state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_q     <= '0;
            idx_q      <= '0;
            prog_q     <= 1'b0;
            bank_q     <= '0;
            first_rd_q <= '0;
            tmo_q      <= 1'b0;
            vfail_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    prog_q  <= op_prog;
                    bank_q  <= bank_sel;
                    step_q  <= '0;
                    idx_q   <= '0;
                    tmo_q   <= 1'b0;
                    vfail_q <= 1'b0;
                end
                ST_CMD_GAP: if (gap_done && !entry.last) step_q <= step_q + 3'd1;
                ST_POLL_CAP1: first_rd_q <= fl_rdata;
                ST_POLL_CAP2: begin
                    if (pair_equal) begin
                        step_q <= '0;
                        idx_q  <= (prog_q && !last_byte) ? idx_q + OFF_W'(1) : '0;
                    end else if (pair_at_limit) begin
                        tmo_q <= 1'b1;
                        idx_q <= '0;
                    end
                end
                ST_VFY_CAP: begin
                    if (fl_rdata != vfy_expect) vfail_q <= 1'b1;
                    idx_q <= idx_q + OFF_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_addr  = {bank_q, {OFF_W{1'b0}}};
        fl_wdata = 8'h00;
        done     = 1'b0;
        unique case (state_q)
            ST_CMD_WR: begin
                fl_we = 1'b1;
                unique case (entry.asel)
                    AS_KEY_A: fl_addr = {bank_q, OFS_A};
                    AS_KEY_B: fl_addr = {bank_q, OFS_B};
                    AS_BASE:  fl_addr = {bank_q, {OFF_W{1'b0}}};
                    AS_BYTE:  fl_addr = {bank_q, idx_q};
                    default:  fl_addr = {bank_q, {OFF_W{1'b0}}};
                endcase
                fl_wdata = entry.use_src ? src_data : entry.data;
            end
            ST_POLL_RD1, ST_POLL_RD2: fl_re = 1'b1;
            ST_EXIT_WR: begin
                fl_we    = 1'b1;
                fl_wdata = EXIT_CMD;
            end
            ST_VFY_RD: begin
                fl_re   = 1'b1;
                fl_addr = {bank_q, idx_q};
            end
            ST_FIN: done = 1'b1;
            default: ;
        endcase
    end

    assign src_addr    = idx_q;
    assign busy        = (state_q != ST_IDLE);
    assign timeout     = tmo_q;
    assign verify_fail = vfail_q;

endmodule

// File: rtl/ufs_seq_checker.sv
module ufs_seq_checker #(
    parameter int BANK_W     = 1,
    parameter int OFF_W      = 13,
    parameter int GAP_CYCLES = 125
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic                    fl_we,
    input logic                    fl_re,
    input logic [BANK_W+OFF_W-1:0] fl_addr,
    input logic [BANK_W-1:0]       bank_sel,
    input logic                    timeout,
    input logic                    verify_fail
);
    localparam logic [31:0] SAT = 32'(GAP_CYCLES + 1);

    logic [31:0]       since_we;
    logic [BANK_W-1:0] bank_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_we <= SAT;
            bank_lat <= '0;
        end else begin
            if (fl_we)               since_we <= 32'd1;
            else if (since_we < SAT) since_we <= since_we + 32'd1;
            if (start && !busy)      bank_lat <= bank_sel;
        end
    end

    assert_excl_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_we, fl_re}));

    assert_in_bank_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we || fl_re) |-> (fl_addr[BANK_W+OFF_W-1:OFF_W] == bank_lat));

    assert_write_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we || fl_re) |-> (since_we > 32'(GAP_CYCLES)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(timeout) && $stable(verify_fail)));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_we && !fl_re && !done));

endmodule

bind unlock_flash_seq ufs_seq_checker #(
    .BANK_W     (BANK_W),
    .OFF_W      (OFF_W),
    .GAP_CYCLES (GAP_CYCLES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fl_we       (fl_we),
    .fl_re       (fl_re),
    .fl_addr     (fl_addr),
    .bank_sel    (bank_sel),
    .timeout     (timeout),
    .verify_fail (verify_fail)
);

// File: tb/unlock_flash_seq_tb_top.sv
module unlock_flash_seq_tb_top;
    localparam int BB  = 32;
    localparam int GAP = 3;
    localparam int PL  = 8;
    localparam int UA  = 'h15;
    localparam int UB  = 'h0A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op_prog = 1'b0;
    logic [0:0] bank_sel = 1'b0;
    logic [4:0] src_addr;
    logic [7:0] src_data;
    logic [5:0] fl_addr;
    logic [7:0] fl_wdata;
    logic       fl_we, fl_re;
    logic [7:0] fl_rdata;
    logic       busy, done, timeout, verify_fail;

    always #4 clk = ~clk;

    unlock_flash_seq #(
        .BANK_BYTES(BB), .BANK_W(1), .UNLOCK_A_OFF(UA), .UNLOCK_B_OFF(UB),
        .GAP_CYCLES(GAP), .POLL_LIMIT(PL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog),
        .bank_sel(bank_sel), .src_addr(src_addr), .src_data(src_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .busy(busy), .done(done), .timeout(timeout),
        .verify_fail(verify_fail)
    );

    // source buffer
    logic [7:0] src_buf [BB];
    assign src_data = src_buf[src_addr];

    // behavioural flash model
    logic [7:0] mem [2*BB];
    logic [7:0] last_w, tog;
    int         busy_left, busy_len;
    logic [7:0] fault_mask;
    int         fault_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_left <= 0; last_w <= 8'h00; tog <= 8'h2C; fl_rdata <= 8'h00;
        end else begin
            if (fl_we) begin
                if (last_w == 8'hA0) begin
                    mem[fl_addr] <= fl_wdata & ~fault_mask;
                    busy_left <= busy_len;
                end else if (fl_wdata == 8'h30 && last_w == 8'h55) begin
                    for (int j = 0; j < BB; j++)
                        mem[{fl_addr[5], 5'(j)}] <= (j == fault_idx) ? 8'h00 : 8'hFF;
                    busy_left <= busy_len;
                end
                last_w <= fl_wdata;
            end
            if (fl_re) begin
                if (busy_left > 0) begin
                    tog <= tog ^ 8'h40;
                    fl_rdata <= tog ^ 8'h40;
                    busy_left <= busy_left - 1;
                end else begin
                    fl_rdata <= mem[fl_addr];
                end
            end
        end
    end

    // bookkeeping
    int checks = 0, fails = 0, cyc = 0, last_we_cyc = -100;
    int poll_reads, vfy_reads;
    logic seen_exit;
    logic [5:0] exp_addr [$];
    logic [7:0] exp_data [$];
    string      exp_tag  [$];
    logic       cur_bank;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int off, input logic [7:0] d, input string tag);
        exp_addr.push_back({cur_bank, 5'(off)});
        exp_data.push_back(d);
        exp_tag.push_back(tag);
    endtask

    // per-cycle comparison of the bus against the expected stream
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (fl_we && fl_re) check(1'b0, "R12 strobe overlap", 1, 0);
            if ((fl_we || fl_re) && fl_addr[5] != cur_bank)
                check(1'b0, "R12 bank", int'(fl_addr), int'(cur_bank));
            if ((fl_we || fl_re) && (cyc - last_we_cyc) <= GAP)
                check(1'b0, "R5 spacing", cyc - last_we_cyc, GAP + 1);
            if (fl_re) begin
                if (seen_exit) vfy_reads++;
                else begin
                    poll_reads++;
                    if (fl_addr[4:0] != 5'd0) check(1'b0, "R6 poll addr", int'(fl_addr), 0);
                end
            end
            if (fl_we) begin
                last_we_cyc = cyc;
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R7 extra write", int'(fl_wdata), 0);
                end else begin
                    string t;
                    t = exp_tag.pop_front();
                    check(fl_addr == exp_addr[0] && fl_wdata == exp_data[0], t,
                          int'({fl_addr, fl_wdata}), int'({exp_addr[0], exp_data[0]}));
                    if (exp_data[0] == 8'hF0 && t == "R8") seen_exit = 1'b1;
                    void'(exp_addr.pop_front());
                    void'(exp_data.pop_front());
                end
            end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_op(input logic prog, input logic bank, input int nbytes,
                          input logic poke_start);
        cur_bank = bank;
        if (!prog) begin
            push(UA, 8'hAA, "R2"); push(UB, 8'h55, "R2"); push(UA, 8'h80, "R3");
            push(UA, 8'hAA, "R2"); push(UB, 8'h55, "R2"); push(0, 8'h30, "R3");
        end else begin
            for (int i = 0; i < nbytes; i++) begin
                push(UA, 8'hAA, "R2"); push(UB, 8'h55, "R2");
                push(UA, 8'hA0, "R4"); push(i, src_buf[i], "R4");
            end
        end
        push(0, 8'hF0, "R8");
        seen_exit = 1'b0; poll_reads = 0; vfy_reads = 0;
        @(negedge clk); start = 1'b1; op_prog = prog; bank_sel = bank;
        @(negedge clk); start = 1'b0;
        if (poke_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1; op_prog = ~prog; bank_sel = ~bank;
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(exp_addr.size() == 0, "R11 write stream complete", exp_addr.size(), 0);
        check(vfy_reads == BB, "R9 verify reads", vfy_reads, BB);
        @(negedge clk);
        check(!done && !busy, "R10 done pulse", {done, busy}, 0);
    endtask

    initial begin
        for (int i = 0; i < BB; i++) src_buf[i] = 8'(i * 7 + 3) ^ 8'h5A;
        for (int i = 0; i < 2 * BB; i++) mem[i] = 8'h00;
        busy_len = 4; fault_mask = 8'h00; fault_idx = -1; cur_bank = 1'b0;
        seen_exit = 1'b0; poll_reads = 0; vfy_reads = 0;
        repeat (3) @(negedge clk);
        check({busy, done, fl_we, fl_re, timeout, verify_fail} == 6'b0, "R1 reset outputs",
              {busy, done, fl_we, fl_re, timeout, verify_fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, fl_we, fl_re, timeout, verify_fail} == 6'b0, "R1 idle after reset",
              {busy, done, fl_we, fl_re, timeout, verify_fail}, 0);

        // R3 erase bank 0, 4 busy reads -> 3 pairs
        run_op(1'b0, 1'b0, 0, 1'b0);
        check(poll_reads == 6, "R6 poll pairs erase", poll_reads, 6);
        check(!timeout && !verify_fail, "R9 erase clean", {timeout, verify_fail}, 0);

        // R4 program bank 0, no busy -> one pair per byte
        busy_len = 0;
        run_op(1'b1, 1'b0, BB, 1'b0);
        check(poll_reads == 2 * BB, "R6 poll pairs program", poll_reads, 2 * BB);
        check(!timeout && !verify_fail, "R4 program clean", {timeout, verify_fail}, 0);

        // R11 erase bank 1 with stray start mid-run
        busy_len = 3;
        run_op(1'b0, 1'b1, 0, 1'b1);
        check(!verify_fail, "R11 erase unaffected", verify_fail, 0);

        // R9 program bank 1 with a stuck bit
        fault_mask = 8'h01; busy_len = 1;
        run_op(1'b1, 1'b1, BB, 1'b0);
        check(verify_fail == 1'b1, "R9 program mismatch", verify_fail, 1);
        fault_mask = 8'h00;

        // R9 erase bank 0 with a stuck byte
        fault_idx = 7;
        run_op(1'b0, 1'b0, 0, 1'b0);
        check(verify_fail == 1'b1, "R9 erase mismatch", verify_fail, 1);
        fault_idx = -1;

        // R7 program timeout aborts after first byte
        busy_len = 1000;
        run_op(1'b1, 1'b0, 1, 1'b0);
        check(timeout == 1'b1, "R7 timeout flag", timeout, 1);
        check(poll_reads == 2 * PL, "R7 pair limit", poll_reads, 2 * PL);
        repeat (5) @(negedge clk);
        check(timeout == 1'b1, "R10 flag held", timeout, 1);

        // R10 next start clears flags
        busy_len = 2;
        run_op(1'b0, 1'b0, 0, 1'b0);
        check(!timeout && !verify_fail, "R10 flags cleared", {timeout, verify_fail}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule